// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a physical address by adding it to a segment base that is the value of one of four segment registers moved up by four bit positions. The four registers hold the code, stack, data and extra segment bases. They are loaded through a write port. The requester does not name a segment. It states what kind of access it makes, and the block picks the segment that applies to that kind. A data or stack access can also carry an explicit segment override that replaces the default choice.

The sum can carry one bit past the 1 MB boundary. A gate input decides what happens to that carry. With the gate open, the block presents a 21-bit address that can reach the 64 KB just above 1 MB. With the gate closed, it drops the carry and the address wraps to low memory. The result comes out one clock after the request, in a register, together with a valid strobe and the code of the segment that was used.

Top module: `rma_real_addr_gen`

## Requirements
- R1: After reset the code segment register holds 0xFFFF and the other three hold 0x0000. `out_valid` is low while reset is active.
- R2: A request accepted on a clock edge (`req_valid` high) produces `out_valid` high on the next edge. `out_addr` then equals segment × 16 + offset, where the offset is 16 bits and the segment is the one the other requirements select.
- R3: Access kind encoding on `req_kind` gives the default segment: 2'b00 general data uses the data segment, 2'b01 stack uses the stack segment, 2'b10 instruction fetch uses the code segment, and 2'b11 string destination uses the extra segment.
- R4: If `ovr_en` is high on a kind other than fetch, the segment named by `ovr_sel` is used in place of the default.
- R5: An instruction fetch always uses the code segment, whatever `ovr_en` and `ovr_sel` hold.
- R6: Segment codes are the same on `seg_wr_sel`, `ovr_sel` and `out_seg`: 0 extra, 1 code, 2 stack, 3 data. A write with `seg_wr_en` high loads `seg_wr_data` into the addressed register, and `out_seg` reports the code of the segment that formed the address.
- R7: With `a20_open` high at the request, a carry out of bit 19 appears on `out_addr[20]`. The largest address is 0x10FFEF.
- R8: With `a20_open` low at the request, `out_addr[20]` is 0, so a sum of 0x100000 or more wraps to sum − 0x100000.
- R9: A request and a write to the same register on the same edge use the value held before the write. The new value applies from the next request on.
- R10: An edge with `req_valid` low gives `out_valid` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Code of the register to load |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | Access kind of the request |
| ovr_en | input | 1 | Explicit segment override present |
| ovr_sel | input | 2 | Code of the override segment |
| req_offset | input | 16 | Offset within the segment |
| a20_open | input | 1 | High keeps the carry into bit 20, low wraps at 1 MB |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 21 | Physical address |
| out_seg | output | 2 | Code of the segment used |

## Verification
Two situations are hard to reach from the ports. The first is a request that meets a write to its own segment register on the same edge. The bench makes it happen on purpose by driving both in one cycle with the request's selection aimed at the register being written. It then follows with a second request that must see the new value. The second is the carry past 1 MB. Only the code segment starts at 0xFFFF, so the bench fetches straight out of reset with the gate in both positions and with the largest offset. It then loads high bases into the other registers and mixes them with random offsets, kinds, overrides and gate levels. A behavioural model checks every cycle.

// File: rtl/rma_pkg.sv
package rma_pkg;

   typedef enum logic [1:0] {
      SEG_EXTRA = 2'd0,
      SEG_CODE  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_DATA  = 2'd3
   } seg_id_e;

   typedef enum logic [1:0] {
      ACC_DATA  = 2'd0,
      ACC_STACK = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_DEST  = 2'd3
   } acc_kind_e;

   localparam int unsigned SEG_COUNT = 4;
   localparam int unsigned SEG_ID_W  = 2;

endpackage

// File: rtl/rma_seg_file.sv
module rma_seg_file
   import rma_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [SEG_ID_W-1:0]                wr_sel,
   input  logic [SEG_W-1:0]                   wr_data,
   output logic [SEG_COUNT-1:0][SEG_W-1:0]    seg_q
);

   if (SEG_W < 2) begin : g_bad_width
      $error("rma_seg_file: SEG_W must be at least 2");
   end

   for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_reg
      localparam logic [SEG_W-1:0] RST_VAL =
         (gi == int'(SEG_CODE)) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
      logic hit;
      assign hit = wr_en && (wr_sel == SEG_ID_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   seg_q[gi] <= RST_VAL;
         else if (hit) seg_q[gi] <= wr_data;
      end
   end

   // R1: the code register comes out of reset at all ones
   a_r1_code_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> seg_q[SEG_CODE] == {SEG_W{1'b1}});

   // R6: a write reaches the addressed register
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/rma_seg_pick.sv
module rma_seg_pick
   import rma_pkg::*;
(
   input  logic [1:0]          kind,
   input  logic                ovr_en,
   input  logic [SEG_ID_W-1:0] ovr_sel,
   output logic [SEG_ID_W-1:0] seg_sel
);

   logic [SEG_ID_W-1:0] dflt;

   always_comb begin
      unique case (acc_kind_e'(kind))
         ACC_DATA:  dflt = SEG_DATA;
         ACC_STACK: dflt = SEG_STACK;
         ACC_FETCH: dflt = SEG_CODE;
         default:   dflt = SEG_EXTRA;
      endcase
   end

   always_comb begin
      if (ovr_en && (acc_kind_e'(kind) != ACC_FETCH)) seg_sel = ovr_sel;
      else                                            seg_sel = dflt;
   end

   // R5: a fetch never leaves the code segment
   always_comb begin
      a_r5_fetch_code: assert (acc_kind_e'(kind) != ACC_FETCH || seg_sel == SEG_CODE);
   end

endmodule

// File: rtl/rma_addr_form.sv
module rma_addr_form #(
   parameter int unsigned SEG_W    = 16,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned SHIFT    = 4,
   parameter bit          HAS_GATE = 1'b1,
   parameter int unsigned ADDR_W   = 21
) (
   input  logic [SEG_W-1:0]  seg_val,
   input  logic [OFF_W-1:0]  offset,
   input  logic              gate_open,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned BASE_W = SEG_W + SHIFT;
   localparam int unsigned SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

   if (SUM_W != ADDR_W) begin : g_bad_addr
      $error("rma_addr_form: ADDR_W must be one more than the wider addend");
   end

   logic [SUM_W-1:0] base_ext;
   logic [SUM_W-1:0] off_ext;
   logic [SUM_W-1:0] sum;

   assign base_ext = SUM_W'({seg_val, {SHIFT{1'b0}}});
   assign off_ext  = SUM_W'(offset);
   assign sum      = base_ext + off_ext;

   if (HAS_GATE) begin : g_gated
      assign addr = {sum[SUM_W-1] & gate_open, sum[SUM_W-2:0]};
   end else begin : g_wrap_only
      logic unused_gate;
      assign unused_gate = gate_open;
      assign addr = {1'b0, sum[SUM_W-2:0]};
   end

endmodule

// File: rtl/rma_real_addr_gen.sv
module rma_real_addr_gen
   import rma_pkg::*;
#(
   parameter int unsigned SEG_W    = 16,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned SHIFT    = 4,
   parameter bit          HAS_GATE = 1'b1,
   parameter int unsigned ADDR_W   =
      (((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                seg_wr_en,
   input  logic [1:0]          seg_wr_sel,
   input  logic [SEG_W-1:0]    seg_wr_data,
   input  logic                req_valid,
   input  logic [1:0]          req_kind,
   input  logic                ovr_en,
   input  logic [1:0]          ovr_sel,
   input  logic [OFF_W-1:0]    req_offset,
   input  logic                a20_open,
   output logic                out_valid,
   output logic [ADDR_W-1:0]   out_addr,
   output logic [1:0]          out_seg
);

   localparam logic [ADDR_W-1:0] TOP_ADDR =
      ADDR_W'({SEG_W{1'b1}}) * ADDR_W'(1 << SHIFT) + ADDR_W'({OFF_W{1'b1}});

   if (SHIFT < 1 || SHIFT > 8) begin : g_bad_shift
      $error("rma_real_addr_gen: SHIFT out of range");
   end

   logic [SEG_COUNT-1:0][SEG_W-1:0] seg_q;
   logic [SEG_ID_W-1:0]             pick;
   logic [ADDR_W-1:0]               addr_d;

   rma_seg_file #(.SEG_W(SEG_W)) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .seg_q   (seg_q)
   );

   rma_seg_pick u_pick (
      .kind    (req_kind),
      .ovr_en  (ovr_en),
      .ovr_sel (ovr_sel),
      .seg_sel (pick)
   );

   rma_addr_form #(
      .SEG_W    (SEG_W),
      .OFF_W    (OFF_W),
      .SHIFT    (SHIFT),
      .HAS_GATE (HAS_GATE),
      .ADDR_W   (ADDR_W)
   ) u_form (
      .seg_val   (seg_q[pick]),
      .offset    (req_offset),
      .gate_open (a20_open),
      .addr      (addr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_seg   <= SEG_EXTRA;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_addr <= addr_d;
            out_seg  <= pick;
         end
      end
   end

   // R2: a request yields a strobe on the next cycle
   a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   // R10: no request, no strobe
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);

   // R7: the result never passes the top of reach
   a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_addr <= TOP_ADDR);

   // R8: a closed gate leaves bit 20 clear
   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !a20_open |=> !out_addr[ADDR_W-1]);

   // R4: an override on a non-fetch access picks the named segment
   a_r4_override: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && ovr_en && req_kind != ACC_FETCH |=> out_seg == $past(ovr_sel));

   // R5: fetch reports the code segment
   a_r5_fetch_out: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == ACC_FETCH |=> out_seg == SEG_CODE);

endmodule

// File: tb/rma_real_addr_gen_tb_top.sv
module rma_real_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr_en = 1'b0;
   logic [1:0]  seg_wr_sel = 2'd0;
   logic [15:0] seg_wr_data = 16'd0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_sel = 2'd0;
   logic [15:0] req_offset = 16'd0;
   logic        a20_open = 1'b1;
   logic        out_valid;
   logic [20:0] out_addr;
   logic [1:0]  out_seg;

   int n_checks = 0;
   int n_fail   = 0;
   bit checking = 1'b0;

   always #2.5 clk = ~clk;

   rma_real_addr_gen dut_i (
      .clk (clk), .rst_n (rst_n),
      .seg_wr_en (seg_wr_en), .seg_wr_sel (seg_wr_sel), .seg_wr_data (seg_wr_data),
      .req_valid (req_valid), .req_kind (req_kind), .ovr_en (ovr_en),
      .ovr_sel (ovr_sel), .req_offset (req_offset), .a20_open (a20_open),
      .out_valid (out_valid), .out_addr (out_addr), .out_seg (out_seg)
   );

   // behavioural reference
   int unsigned segs[4];
   bit          exp_valid;
   int unsigned exp_addr;
   int unsigned exp_seg;
   string       exp_tag;

   task automatic model_reset();
      segs[0] = 0; segs[1] = 32'hFFFF; segs[2] = 0; segs[3] = 0;
      exp_valid = 1'b0; exp_addr = 0; exp_seg = 0; exp_tag = "R1";
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         int unsigned s;
         int unsigned a;
         exp_valid = req_valid;
         if (req_valid) begin
            exp_tag = "R2";
            case (req_kind)
               2'd0: s = 3;
               2'd1: s = 2;
               2'd2: s = 1;
               default: s = 0;
            endcase
            if (req_kind != 2'd2 && ovr_en) begin s = ovr_sel; exp_tag = "R4"; end
            if (req_kind == 2'd2 && ovr_en) exp_tag = "R5";
            a = segs[s] * 16 + req_offset;
            if (a >= 32'h100000) begin
               if (!a20_open) begin a = a - 32'h100000; exp_tag = "R8"; end
               else exp_tag = "R7";
            end
            exp_addr = a;
            exp_seg  = s;
         end
         if (seg_wr_en) segs[seg_wr_sel] = seg_wr_data;
      end
   end

   task automatic check(string tag, int unsigned act, int unsigned exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         check(exp_valid ? "R2" : "R10", out_valid, exp_valid, "out_valid");
         if (exp_valid && out_valid) begin
            check(exp_tag, out_addr, exp_addr, "out_addr");
            check("R6", out_seg, exp_seg, "out_seg");
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      seg_wr_en = 1'b0; req_valid = 1'b0; ovr_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val; req_valid = 1'b0;
   endtask

   task automatic rq(input logic [1:0] kind, input logic oe, input logic [1:0] os,
                     input logic [15:0] off, input logic gate);
      @(negedge clk);
      seg_wr_en = 1'b0; req_valid = 1'b1; req_kind = kind; ovr_en = oe;
      ovr_sel = os; req_offset = off; a20_open = gate;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      check("R1", out_valid, 0, "out_valid in reset");
      rst_n = 1'b1;
      checking = 1'b1;
      // R1 / R7: code base 0xFFFF straight from reset, carry kept
      rq(2'd2, 1'b0, 2'd0, 16'h0010, 1'b1);
      // R8: same sum with gate closed wraps to 0
      rq(2'd2, 1'b0, 2'd0, 16'h0010, 1'b0);
      // R7: top of reach 0x10FFEF
      rq(2'd2, 1'b0, 2'd0, 16'hFFFF, 1'b1);
      // R1: other segments zero
      rq(2'd0, 1'b0, 2'd0, 16'h1234, 1'b1);
      rq(2'd1, 1'b0, 2'd0, 16'h00FF, 1'b1);
      rq(2'd3, 1'b0, 2'd0, 16'hABCD, 1'b1);
      idle();
      // R6: load distinct bases
      wr(2'd0, 16'h1000);
      wr(2'd2, 16'h2000);
      wr(2'd3, 16'h3000);
      wr(2'd1, 16'hF800);
      idle();
      // R3: default per kind
      rq(2'd0, 1'b0, 2'd0, 16'h0004, 1'b1);
      rq(2'd1, 1'b0, 2'd0, 16'h0008, 1'b1);
      rq(2'd2, 1'b0, 2'd0, 16'h000C, 1'b1);
      rq(2'd3, 1'b0, 2'd0, 16'h0010, 1'b1);
      // R4: override on data and stack
      rq(2'd0, 1'b1, 2'd0, 16'h0001, 1'b1);
      rq(2'd1, 1'b1, 2'd1, 16'h9000, 1'b0);
      // R5: fetch ignores override
      rq(2'd2, 1'b1, 2'd3, 16'h0002, 1'b1);
      idle();
      idle();
      // R9: write and request to the same register on one edge
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h4444;
      req_valid = 1'b1; req_kind = 2'd0; ovr_en = 1'b0; req_offset = 16'h0005; a20_open = 1'b1;
      rq(2'd0, 1'b0, 2'd0, 16'h0005, 1'b1);
      idle();
      // random mix with high bases
      wr(2'd3, 16'hFFF0);
      wr(2'd2, 16'hF000);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         seg_wr_en   = ($urandom % 8) == 0;
         seg_wr_sel  = 2'($urandom);
         seg_wr_data = 16'($urandom) | 16'hE000;
         req_valid   = ($urandom % 4) != 0;
         req_kind    = 2'($urandom);
         ovr_en      = ($urandom % 3) == 0;
         ovr_sel     = 2'($urandom);
         req_offset  = 16'($urandom);
         a20_open    = $urandom % 2;
      end
      idle();
      idle();
      idle();
      checking = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule